// File: doc/BRIEF.md
# Receive Frame Length Screening and Traffic Statistics

This block sits after the receive framer and CRC checker of an Ethernet MAC. For every completed frame it gets a one-cycle done strobe together with the payload length (destination address through the last data byte, FCS excluded) and two control bits: one that allows long frames and one that asks the MAC to keep frames it would otherwise reject. From these it decides whether the frame is dropped for being too long, and it keeps a set of saturating statistics counters.

Accepted frames are sorted into six size bins by their on-wire length (payload plus the four FCS bytes). They also advance a packet total and a double-width octet total. Dropped frames only advance an oversize counter. Every counter stops at its all-ones value instead of wrapping. Software reads the counters through a simple registered read port. The packet and octet totals also appear at a second set of addresses, which serve as the "good" copies.

Top module: `rxlen_stats`

## Requirements
- R1: A frame is oversized when its payload length (FCS excluded) exceeds MAX_LONG (16384), or exceeds MAX_STD (1522) while `long_en` is 0. An oversized frame with `store_bad` at 0 is dropped: `drop` is 1 for exactly the cycle after its `frm_done` strobe and 0 in every other cycle. A dropped frame changes no bin, packet or octet counter.
- R2: When `store_bad` is 1, the frame never raises `drop`, whatever its length. It is counted as an accepted frame.
- R3: Each dropped frame adds one to the oversize counter at address 12.
- R4: Accepted frames are binned by on-wire length L = payload + 4. Address 0 counts L == 64. Address 1 counts 65..127. Address 2 counts 128..255. Address 3 counts 256..511. Address 4 counts 512..1023. Address 5 counts L >= 1024.
- R5: An accepted frame with L below 64 changes no bin counter.
- R6: Every accepted frame adds one to the packet total, which reads at address 6 and again at address 7.
- R7: Every accepted frame adds L to the octet total, which is 2*CNT_W bits wide. Its low word reads at address 8 and its high word at address 9. The same words read again at addresses 10 and 11.
- R8: The bin, packet and oversize counters hold at all-ones instead of wrapping.
- R9: If adding L would carry out of the octet total, both of its words become all-ones. After that they stay at all-ones.
- R10: `rd_data` is registered and returns the word at the `rd_addr` of the previous cycle. A read whose address is presented in the same cycle as `frm_done` returns the value from before that frame. Addresses 13 to 15 read as zero.
- R11: While `rst` is high, all counters clear and `drop` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a frame has completed |
| frm_len | input | LEN_W | Payload length in bytes, FCS excluded |
| long_en | input | 1 | Allow frames up to MAX_LONG |
| store_bad | input | 1 | Keep oversized frames instead of dropping them |
| drop | output | 1 | Frame of the previous cycle is dropped as oversized |
| rd_addr | input | 4 | Statistics register select |
| rd_data | output | CNT_W | Registered read data |

## Verification
Both results of a frame are due one clock edge after its strobe: the `drop` pulse and the counter update. A read result is due one edge after its address. The driver applies every stimulus at the falling edge and queues the expected drop flag. The monitor compares `drop` at the next falling edge, half a period after the register has loaded. Counter reads also sample at the falling edge after the address was applied. One stimulus presents a read address in the same cycle as a frame strobe and checks the old value, then the new one a cycle later. The bench runs with 8-bit counters, so that saturation of every counter and of the 16-bit octet total can be reached within the run.

// File: rtl/rxlen_pkg.sv
package rxlen_pkg;
  localparam int NUM_BKT = 6;
  localparam int IDX_TOT = NUM_BKT;
  localparam int IDX_OVS = NUM_BKT + 1;
  localparam int NUM_CNT = NUM_BKT + 2;
  localparam int ADDR_W  = 4;
  localparam int FCS_LEN = 4;

  localparam logic [ADDR_W-1:0] A_TOT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_GTOT = 4'd7;
  localparam logic [ADDR_W-1:0] A_OLO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_OHI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_GOLO = 4'd10;
  localparam logic [ADDR_W-1:0] A_GOHI = 4'd11;
  localparam logic [ADDR_W-1:0] A_OVS  = 4'd12;

  // lower on-wire length bound of each size bin
  function automatic int bkt_lo(int idx);
    case (idx)
      0:       return 64;
      1:       return 65;
      2:       return 128;
      3:       return 256;
      4:       return 512;
      default: return 1024;
    endcase
  endfunction
endpackage

// File: rtl/rxlen_classify.sv
module rxlen_classify
  import rxlen_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_STD  = 1522,
  parameter int MAX_LONG = 16384
) (
  input  logic [LEN_W-1:0]   len,
  input  logic               long_en,
  input  logic               store_bad,
  output logic               drop_now,
  output logic [NUM_BKT-1:0] bkt,
  output logic [LEN_W:0]     wire_len
);
  localparam logic [LEN_W:0] LIM_STD  = (LEN_W+1)'(MAX_STD);
  localparam logic [LEN_W:0] LIM_LONG = (LEN_W+1)'(MAX_LONG);

  logic [LEN_W:0] len_x;
  logic           too_long;

  assign len_x    = {1'b0, len};
  assign wire_len = len_x + (LEN_W+1)'(FCS_LEN);
  assign too_long = (len_x > LIM_LONG) || (!long_en && (len_x > LIM_STD));
  assign drop_now = too_long && !store_bad;

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_bkt
    localparam logic [LEN_W:0] LO = (LEN_W+1)'(bkt_lo(i));
    if (i == NUM_BKT - 1) begin : g_top
      assign bkt[i] = (wire_len >= LO);
    end else begin : g_mid
      localparam logic [LEN_W:0] HI = (LEN_W+1)'(bkt_lo(i+1) - 1);
      assign bkt[i] = (wire_len >= LO) && (wire_len <= HI);
    end
  end
endmodule

// File: rtl/rxlen_sat_cnt.sv
module rxlen_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (inc && (q != {W{1'b1}})) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/rxlen_oct_acc.sv
module rxlen_oct_acc #(
  parameter int W  = 64,
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_en,
  input  logic [AW-1:0] add_val,
  output logic [W-1:0]  tot
);
  localparam int SW = ((W > AW) ? W : AW) + 1;
  localparam logic [SW-1:0] TOP = SW'({W{1'b1}});

  logic [SW-1:0] sum;
  assign sum = SW'(tot) + SW'(add_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      tot <= '0;
    end else if (add_en) begin
      if (sum > TOP) tot <= {W{1'b1}};
      else           tot <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/rxlen_stats.sv
module rxlen_stats
  import rxlen_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 32,
  parameter int MAX_STD  = 1522,
  parameter int MAX_LONG = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              long_en,
  input  logic              store_bad,
  output logic              drop,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int OCT_W = 2 * CNT_W;

  logic               drop_now;
  logic [NUM_BKT-1:0] bkt;
  logic [LEN_W:0]     wire_len;
  logic               accept;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [CNT_W-1:0]   tot_cnt;
  logic [CNT_W-1:0]   ovs_cnt;
  logic [OCT_W-1:0]   oct_tot;
  logic [CNT_W-1:0]   rd_nxt;

  rxlen_classify #(
    .LEN_W(LEN_W), .MAX_STD(MAX_STD), .MAX_LONG(MAX_LONG)
  ) u_cls (
    .len(frm_len), .long_en(long_en), .store_bad(store_bad),
    .drop_now(drop_now), .bkt(bkt), .wire_len(wire_len)
  );

  assign accept = frm_done && !drop_now;

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_inc
    assign inc[i] = accept && bkt[i];
  end
  assign inc[IDX_TOT] = accept;
  assign inc[IDX_OVS] = frm_done && drop_now;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    rxlen_sat_cnt #(.W(CNT_W)) u_c (
      .clk(clk), .rst(rst), .inc(inc[i]), .q(cnt_val[i])
    );
  end

  assign tot_cnt = cnt_val[IDX_TOT];
  assign ovs_cnt = cnt_val[IDX_OVS];

  rxlen_oct_acc #(.W(OCT_W), .AW(LEN_W+1)) u_oct (
    .clk(clk), .rst(rst), .add_en(accept), .add_val(wire_len), .tot(oct_tot)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_BKT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_nxt = cnt_val[i];
    end
    case (rd_addr)
      A_TOT, A_GTOT: rd_nxt = tot_cnt;
      A_OLO, A_GOLO: rd_nxt = oct_tot[CNT_W-1:0];
      A_OHI, A_GOHI: rd_nxt = oct_tot[OCT_W-1:CNT_W];
      A_OVS:         rd_nxt = ovs_cnt;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop    <= 1'b0;
      rd_data <= '0;
    end else begin
      drop    <= frm_done && drop_now;
      rd_data <= rd_nxt;
    end
  end
endmodule

// File: rtl/rxlen_stats_chk.sv
module rxlen_stats_chk #(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               frm_done,
  input logic               store_bad,
  input logic               drop,
  input logic [CNT_W-1:0]   tot_cnt,
  input logic [CNT_W-1:0]   ovs_cnt,
  input logic [2*CNT_W-1:0] oct_tot
);
  // R1
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    drop |-> ($past(frm_done) && !$past(store_bad)));

  // R2
  keep_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && store_bad) |=> !drop);

  // R3
  ovs_step_chk: assert property (@(posedge clk) disable iff (rst)
    drop |-> ((ovs_cnt == CNT_W'($past(ovs_cnt) + 1'b1)) || (ovs_cnt == {CNT_W{1'b1}})));

  // R6
  tot_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_done |=> $stable(tot_cnt));

  // R8
  tot_mono_chk: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> (tot_cnt >= $past(tot_cnt)));

  // R8
  ovs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovs_cnt == {CNT_W{1'b1}}) |=> (ovs_cnt == {CNT_W{1'b1}}));

  // R9
  oct_mono_chk: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> (oct_tot >= $past(oct_tot)));

  // R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!drop && (tot_cnt == '0) && (ovs_cnt == '0) && (oct_tot == '0)));
endmodule

bind rxlen_stats rxlen_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .frm_done(frm_done), .store_bad(store_bad),
  .drop(drop), .tot_cnt(tot_cnt), .ovs_cnt(ovs_cnt), .oct_tot(oct_tot)
);

// File: tb/sim_rxlen_stats.sv
module sim_rxlen_stats;
  localparam int LW = 16;
  localparam int CW = 8;
  localparam longint CMAX = (longint'(1) << CW) - 1;
  localparam longint OMAX = (longint'(1) << (2*CW)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frm_done = 1'b0;
  logic [LW-1:0] frm_len = '0;
  logic          long_en = 1'b0;
  logic          store_bad = 1'b0;
  logic          drop;
  logic [3:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;

  always #10 clk = ~clk;

  rxlen_stats #(.LEN_W(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_len(frm_len),
    .long_en(long_en), .store_bad(store_bad), .drop(drop),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  longint m_bkt [6];
  longint m_tot = 0, m_ovs = 0, m_oct = 0;
  bit     q_exp [$];
  string  q_tag [$];
  logic   vld_q = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) vld_q <= rst ? 1'b0 : frm_done;

  // monitor: drop flag is due one edge after the strobe
  always @(negedge clk) begin
    if (vld_q) begin
      if (q_exp.size() == 0) chk("R1 unexpected frame result", 1, 0);
      else begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, longint'(drop), longint'(e));
      end
    end
  end

  function automatic int bidx(int t);
    if (t < 64)    return -1;
    if (t == 64)   return 0;
    if (t <= 127)  return 1;
    if (t <= 255)  return 2;
    if (t <= 511)  return 3;
    if (t <= 1023) return 4;
    return 5;
  endfunction

  // driver: starts and ends on a falling edge
  task automatic send(int len, bit le, bit sb, string tag);
    int  t;
    bit  over;
    t    = len + 4;
    over = ((len > 16384) || (!le && len > 1522)) && !sb;
    q_exp.push_back(over);
    q_tag.push_back(tag);
    if (over) begin
      if (m_ovs < CMAX) m_ovs++;
    end else begin
      if (bidx(t) >= 0 && m_bkt[bidx(t)] < CMAX) m_bkt[bidx(t)]++;
      if (m_tot < CMAX) m_tot++;
      m_oct = (m_oct + t > OMAX) ? OMAX : m_oct + t;
    end
    frm_len   = LW'(len);
    long_en   = le;
    store_bad = sb;
    frm_done  = 1'b1;
    @(negedge clk);
    frm_done  = 1'b0;
  endtask

  task automatic rd(int a, longint exp, string tag);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(tag, longint'(rd_data), exp);
  endtask

  task automatic rd_all(string tag);
    for (int i = 0; i < 6; i++) rd(i, m_bkt[i], {tag, " R4 bin"});
    rd(6, m_tot, {tag, " R6 total"});
    rd(7, m_tot, {tag, " R6 good mirror"});
    rd(8, m_oct & CMAX, {tag, " R7 octet lo"});
    rd(9, m_oct >> CW, {tag, " R7 octet hi"});
    rd(10, m_oct & CMAX, {tag, " R7 good lo"});
    rd(11, m_oct >> CW, {tag, " R7 good hi"});
    rd(12, m_ovs, {tag, " R3 oversize"});
  endtask

  initial begin
    longint old;
    for (int i = 0; i < 6; i++) m_bkt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R11 drop in reset", longint'(drop), 0);
    rst = 1'b0;
    @(negedge clk);
    rd_all("R11");
    rd(13, 0, "R10 unmapped 13");
    rd(15, 0, "R10 unmapped 15");

    // R10: read in the strobe cycle sees the old value
    old = m_tot;
    rd_addr = 4'd6;
    send(100, 1'b0, 1'b0, "R10 frame");
    chk("R10 same-cycle read", longint'(rd_data), old);
    @(negedge clk);
    chk("R10 next read", longint'(rd_data), m_tot);

    // R4 / R5 bin edges
    send(60,   0, 0, "R4 L=64");
    send(59,   0, 0, "R5 L=63");
    send(10,   0, 0, "R5 L=14");
    send(61,   0, 0, "R4 L=65");
    send(123,  0, 0, "R4 L=127");
    send(124,  0, 0, "R4 L=128");
    send(251,  0, 0, "R4 L=255");
    send(252,  0, 0, "R4 L=256");
    send(507,  0, 0, "R4 L=511");
    send(508,  0, 0, "R4 L=512");
    send(1019, 0, 0, "R4 L=1023");
    send(1020, 0, 0, "R4 L=1024");
    // R1 limits
    send(1522, 0, 0, "R1 1522 short mode kept");
    send(1523, 0, 0, "R1 1523 short mode dropped");
    send(1523, 1, 0, "R1 1523 long mode kept");
    send(16384, 1, 0, "R1 16384 long mode kept");
    send(16385, 1, 0, "R1 16385 long mode dropped");
    // R2 store_bad
    send(16385, 1, 1, "R2 16385 kept");
    send(2000,  0, 1, "R2 2000 short mode kept");
    @(negedge clk);
    chk("R1 drop idle", longint'(drop), 0);
    rd_all("R1R2");

    // R9 octet total saturates as one unit
    for (int i = 0; i < 3; i++) send(16000, 1, 0, "R9 big frame");
    @(negedge clk);
    rd(8, CMAX, "R9 lo all-ones");
    rd(9, CMAX, "R9 hi all-ones");
    send(100, 0, 0, "R9 after saturation");
    rd(8, CMAX, "R9 lo holds");
    rd(9, CMAX, "R9 hi holds");

    // R8 packet, bin and oversize saturation
    for (int i = 0; i < 260; i++) send(60, 0, 0, "R8 small");
    for (int i = 0; i < 260; i++) send(20000, 1, 0, "R8 oversize");
    @(negedge clk);
    rd(6, CMAX, "R8 total saturated");
    rd(0, CMAX, "R8 bin0 saturated");
    rd(12, CMAX, "R8 oversize saturated");
    rd_all("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule